// File: doc/BRIEF.md
# Descriptor-List Audio DMA Channel

This block is one playback channel of an audio controller. It reads a ring of up to 32 buffer descriptors from memory. Each descriptor names a buffer of 16-bit samples. The channel feeds those samples, one per frame tick, to the codec-side sample port. Software places descriptors ahead of the channel and moves a last-valid pointer forward. The channel stops when it finishes the buffer at that pointer. It restarts by itself once the pointer moves on.

A host writes and reads a small register set: list base, current and last-valid index, status, remaining position, the next index and control. Memory is reached through a simple read port. The channel holds a request with its address until an acknowledge arrives together with the data word. Status flags are kept until software writes 1 to clear them. The single interrupt line combines three of these flags with their enables.

Top module: `adma_chan`

## Requirements
- R1: After reset, status reads 0x01 (halted only), current index 0, next index 1, position 0, `irq` low, `mem_req` low and `smp_valid` low.
- R2: Descriptor n sits at list base + 8*n. Word 0 is the buffer byte address. In word 1, bits 15:0 give the sample count, bit 31 requests a completion flag and bit 30 selects zero fill. Sample k is read from buffer + 2*k: address bit 1 = 0 takes data bits 15:0, bit 1 = 1 takes bits 31:16.
- R3: Each `smp_tick` produces exactly one `smp_valid` cycle on the next clock. While running, samples leave in buffer order across descriptors. The index steps by one modulo 32 (31 is followed by 0). The next-index register always reads current + 1 modulo 32. A zero-length descriptor completes with no sample.
- R4: The position register (offset 0x8) loads the descriptor's sample count. It drops by one for each sample delivered.
- R5: When the buffer at the last-valid index finishes, status bit 0 (halted) and bit 2 (last buffer done) are set. The current index stays put and no memory request is made while halted.
- R6: After such a halt, writing a different last-valid index while run is set resumes the channel at current index + 1.
- R7: Status bit 1 is set when the descriptor at the last-valid index is loaded. Status bit 3 is set when a buffer with the completion bit finishes.
- R8: Writing status with a 1 in bits 1..4 clears those bits. Bit 0 is not affected by writes.
- R9: A tick while running and not halted, with no sample ready, is an underrun: status bit 4 is set and a fill sample is sent. The fill is the last delivered sample when the current descriptor's bit 30 is 0, and zero when it is 1. A tick while halted sends the same fill without setting bit 4.
- R10: Control bit 0 is run. While it is 0, no sample is consumed, a tick sends the fill, bit 4 stays clear and the position is kept. Setting it again continues where the channel stopped.
- R11: `irq` is high exactly when any of status bits 2, 3, 4 is set together with control bit 2, 4 or 3 respectively.
- R12: Writing control with bit 1 set clears the current and last-valid indices, the position, status bits 1..4 and run. It leaves the channel halted, and bit 1 reads back 0.
- R13: Registers are addressed by byte offset on `reg_addr`, with data right-aligned on `reg_wdata`/`reg_rdata` and zero-extended: list base 0x0, current index 0x4, last-valid 0x5, status 0x6, position 0x8, next index 0xA, control 0xB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Host write data, right-aligned |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Memory acknowledge, valid with data |
| mem_rdata | input | 32 | Memory read word |
| smp_tick | input | 1 | Codec frame tick requesting one sample |
| smp_valid | output | 1 | Sample present on `smp_data` |
| smp_data | output | 16 | Output sample |
| irq | output | 1 | Interrupt request |

## Verification
Three descriptors are played, one of them starting on an upper half-word and one carrying the completion bit. This separates correct half selection, descriptor order and flag setting from a channel that merely counts samples. Further cases move the last-valid pointer after a halt, pause in mid-buffer, and slow the memory so that a real underrun repeats the last sample. A tick while halted on a zero-fill buffer tells the two fill modes apart. A ring of 31 empty descriptors ending at index 31 drives the index through its wrap to 0 and covers zero-length completion.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int ADMA_AW        = 32;
  localparam int ADMA_DW        = 32;
  localparam int ADMA_SMP_W     = 16;
  localparam int ADMA_IDX_W     = 5;
  localparam int ADMA_LEN_W     = 16;
  localparam int ADMA_IOC_BIT   = 31;
  localparam int ADMA_ZFILL_BIT = 30;
  localparam int ADMA_NFLAG     = 4;

  localparam int CR_RUN  = 0;
  localparam int CR_SRST = 1;
  localparam int CR_W    = 5;

  typedef logic [ADMA_AW-1:0]    addr_t;
  typedef logic [ADMA_DW-1:0]    word_t;
  typedef logic [ADMA_SMP_W-1:0] smp_t;

  typedef enum logic [2:0] {
    S_IDLE, S_BASE, S_LEN, S_DATA, S_HOLD, S_DONE
  } seq_st_e;

  // byte address of word 0 or word 1 of descriptor idx
  function automatic addr_t desc_addr(addr_t list_base, addr_t idx, logic second);
    return list_base + (idx << 3) + (second ? addr_t'(4) : addr_t'(0));
  endfunction

  // byte address of sample k in a buffer
  function automatic addr_t smp_addr(addr_t buf_base, addr_t k);
    return buf_base + (k << 1);
  endfunction

  // pick the half-word addressed by byte-address bit 1
  function automatic smp_t half_pick(word_t w, logic upper);
    return upper ? w[ADMA_DW-1 -: ADMA_SMP_W] : w[ADMA_SMP_W-1:0];
  endfunction
endpackage

// File: rtl/adma_seq.sv
module adma_seq import adma_pkg::*; #(
  parameter int IDX_W = ADMA_IDX_W,
  parameter int LEN_W = ADMA_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             run,
  input  addr_t            list_base,
  input  logic [IDX_W-1:0] lvi,
  input  logic             take,
  output logic             mem_req,
  output addr_t            mem_addr,
  input  logic             mem_ack,
  input  word_t            mem_rdata,
  output logic [IDX_W-1:0] civ,
  output logic [LEN_W-1:0] picb,
  output logic             halted,
  output logic             buf_vld,
  output smp_t             buf_data,
  output logic             zfill,
  output logic             ev_celv,
  output logic             ev_ioc,
  output logic             ev_last
);
  seq_st_e          st;
  addr_t            bbase;
  logic [LEN_W-1:0] sidx;
  logic             ioc_q;
  logic             fin_q;
  logic             ack;
  logic             at_last;
  logic             resume;
  logic [LEN_W-1:0] new_len;

  assign mem_req = run && (st == S_BASE || st == S_LEN || st == S_DATA);
  assign ack     = mem_req && mem_ack;
  assign at_last = (civ == lvi);
  assign resume  = (st == S_IDLE) && halted && run && (!fin_q || !at_last);
  assign new_len = mem_rdata[LEN_W-1:0];

  always_comb begin
    case (st)
      S_BASE:  mem_addr = desc_addr(list_base, addr_t'(civ), 1'b0);
      S_LEN:   mem_addr = desc_addr(list_base, addr_t'(civ), 1'b1);
      default: mem_addr = smp_addr(bbase, addr_t'(sidx));
    endcase
  end

  assign ev_celv = (st == S_LEN) && ack && at_last;
  assign ev_ioc  = (st == S_DONE) && ioc_q;
  assign ev_last = (st == S_DONE) && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; civ <= '0; picb <= '0; halted <= 1'b1; fin_q <= 1'b0;
      bbase <= '0; sidx <= '0; ioc_q <= 1'b0; zfill <= 1'b0;
      buf_vld <= 1'b0; buf_data <= '0;
    end else if (soft_rst) begin
      st <= S_IDLE; civ <= '0; picb <= '0; halted <= 1'b1; fin_q <= 1'b0;
      sidx <= '0; ioc_q <= 1'b0; zfill <= 1'b0; buf_vld <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (resume) begin
          if (fin_q) civ <= civ + 1'b1;
          halted <= 1'b0;
          fin_q  <= 1'b0;
          st     <= S_BASE;
        end
        S_BASE: if (ack) begin
          bbase <= mem_rdata;
          st    <= S_LEN;
        end
        S_LEN: if (ack) begin
          picb  <= new_len;
          ioc_q <= mem_rdata[ADMA_IOC_BIT];
          zfill <= mem_rdata[ADMA_ZFILL_BIT];
          sidx  <= '0;
          st    <= (new_len == '0) ? S_DONE : S_DATA;
        end
        S_DATA: if (ack) begin
          buf_data <= half_pick(mem_rdata, mem_addr[1]);
          buf_vld  <= 1'b1;
          st       <= S_HOLD;
        end
        S_HOLD: if (take) begin
          buf_vld <= 1'b0;
          picb    <= picb - 1'b1;
          sidx    <= sidx + 1'b1;
          st      <= (picb == LEN_W'(1)) ? S_DONE : S_DATA;
        end
        S_DONE: begin
          if (at_last) begin
            halted <= 1'b1;
            fin_q  <= 1'b1;
            st     <= S_IDLE;
          end else begin
            civ <= civ + 1'b1;
            st  <= S_BASE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adma_port.sv
module adma_port import adma_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic tick,
  input  logic run,
  input  logic halted,
  input  logic buf_vld,
  input  smp_t buf_data,
  input  logic zfill,
  output logic take,
  output logic ev_under,
  output logic smp_valid,
  output smp_t smp_data
);
  smp_t last_q;
  smp_t fill;

  assign take     = tick && run && buf_vld;
  assign ev_under = tick && run && !halted && !buf_vld;
  assign fill     = zfill ? '0 : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
      last_q    <= '0;
    end else begin
      smp_valid <= tick;
      if (tick) smp_data <= take ? buf_data : fill;
      if (soft_rst)  last_q <= '0;
      else if (take) last_q <= buf_data;
    end
  end
endmodule

// File: rtl/adma_stat.sv
module adma_stat import adma_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  clr_we,
  input  logic [ADMA_NFLAG-1:0] clr_mask,
  input  logic                  ev_celv,
  input  logic                  ev_last,
  input  logic                  ev_ioc,
  input  logic                  ev_under,
  input  logic                  halted,
  input  logic [2:0]            ien,
  output logic [ADMA_NFLAG:0]   sr,
  output logic                  irq
);
  logic [ADMA_NFLAG-1:0] flag_q;
  logic [ADMA_NFLAG-1:0] set_v;

  assign set_v = {ev_under, ev_ioc, ev_last, ev_celv};

  for (genvar i = 0; i < ADMA_NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flag_q[i] <= 1'b0;
      else if (soft_rst)              flag_q[i] <= 1'b0;
      else if (set_v[i])              flag_q[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) flag_q[i] <= 1'b0;
    end
  end

  assign sr  = {flag_q, halted};
  assign irq = |(flag_q[ADMA_NFLAG-1:1] & ien);
endmodule

// File: rtl/adma_chan.sv
module adma_chan import adma_pkg::*; #(
  parameter int IDX_W = ADMA_IDX_W,
  parameter int LEN_W = ADMA_LEN_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [3:0]            reg_addr,
  input  logic [ADMA_DW-1:0]    reg_wdata,
  output logic [ADMA_DW-1:0]    reg_rdata,
  output logic                  mem_req,
  output logic [ADMA_AW-1:0]    mem_addr,
  input  logic                  mem_ack,
  input  logic [ADMA_DW-1:0]    mem_rdata,
  input  logic                  smp_tick,
  output logic                  smp_valid,
  output logic [ADMA_SMP_W-1:0] smp_data,
  output logic                  irq
);
  localparam logic [3:0] OFS_BASE = 4'h0;
  localparam logic [3:0] OFS_CIV  = 4'h4;
  localparam logic [3:0] OFS_LVI  = 4'h5;
  localparam logic [3:0] OFS_SR   = 4'h6;
  localparam logic [3:0] OFS_PICB = 4'h8;
  localparam logic [3:0] OFS_PIV  = 4'hA;
  localparam logic [3:0] OFS_CR   = 4'hB;

  addr_t             list_base;
  logic [IDX_W-1:0]  lvi;
  logic [CR_W-1:0]   cr_q;
  logic              soft_rst;
  logic              run;
  logic [IDX_W-1:0]  civ;
  logic [IDX_W-1:0]  piv;
  logic [LEN_W-1:0]  picb;
  logic              halted, buf_vld, zfill, take;
  logic              ev_celv, ev_ioc, ev_last, ev_under;
  smp_t              buf_data;
  logic [ADMA_NFLAG:0] sr;

  assign soft_rst = reg_we && (reg_addr == OFS_CR) && reg_wdata[CR_SRST];
  assign run      = cr_q[CR_RUN];
  assign piv      = civ + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      list_base <= '0;
      lvi       <= '0;
      cr_q      <= '0;
    end else if (soft_rst) begin
      lvi  <= '0;
      cr_q <= {reg_wdata[CR_W-1:2], 2'b00};
    end else if (reg_we) begin
      case (reg_addr)
        OFS_BASE: list_base <= reg_wdata;
        OFS_LVI:  lvi       <= reg_wdata[IDX_W-1:0];
        OFS_CR:   cr_q      <= {reg_wdata[CR_W-1:2], 1'b0, reg_wdata[CR_RUN]};
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_BASE: reg_rdata = list_base;
      OFS_CIV:  reg_rdata = word_t'(civ);
      OFS_LVI:  reg_rdata = word_t'(lvi);
      OFS_SR:   reg_rdata = word_t'(sr);
      OFS_PICB: reg_rdata = word_t'(picb);
      OFS_PIV:  reg_rdata = word_t'(piv);
      OFS_CR:   reg_rdata = word_t'(cr_q);
      default:  reg_rdata = '0;
    endcase
  end

  adma_seq #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run),
    .list_base(list_base), .lvi(lvi), .take(take),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .civ(civ), .picb(picb), .halted(halted), .buf_vld(buf_vld), .buf_data(buf_data),
    .zfill(zfill), .ev_celv(ev_celv), .ev_ioc(ev_ioc), .ev_last(ev_last)
  );

  adma_port u_port (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(smp_tick), .run(run),
    .halted(halted), .buf_vld(buf_vld), .buf_data(buf_data), .zfill(zfill),
    .take(take), .ev_under(ev_under), .smp_valid(smp_valid), .smp_data(smp_data)
  );

  adma_stat u_stat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .clr_we(reg_we && (reg_addr == OFS_SR)), .clr_mask(reg_wdata[ADMA_NFLAG:1]),
    .ev_celv(ev_celv), .ev_last(ev_last), .ev_ioc(ev_ioc), .ev_under(ev_under),
    .halted(halted), .ien({cr_q[3], cr_q[4], cr_q[2]}), .sr(sr), .irq(irq)
  );
endmodule

// File: rtl/adma_chan_chk.sv
module adma_chan_chk import adma_pkg::*; #(
  parameter int IDX_W = ADMA_IDX_W,
  parameter int LEN_W = ADMA_LEN_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               soft_rst,
  input logic               run,
  input logic               take,
  input logic               ev_under,
  input logic               halted,
  input logic               mem_req,
  input logic [IDX_W-1:0]   civ,
  input logic [LEN_W-1:0]   picb,
  input logic [ADMA_NFLAG:0] sr,
  input logic               smp_tick,
  input logic               smp_valid
);
  AST_ONE_SAMPLE_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> smp_valid == $past(smp_tick)); // R3
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(civ) && !$past(soft_rst)) |-> civ == $past(civ) + 1'b1); // R3
  AST_POSITION_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !soft_rst) |=> picb == $past(picb) - 1'b1); // R4
  AST_HALT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req); // R5
  AST_UNDERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_under && !soft_rst) |=> sr[4]); // R9
  AST_NO_TAKE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (run && !halted)); // R10
endmodule

bind adma_chan adma_chan_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run), .take(take),
  .ev_under(ev_under), .halted(halted), .mem_req(mem_req), .civ(civ),
  .picb(picb), .sr(sr), .smp_tick(smp_tick), .smp_valid(smp_valid)
);

// File: tb/adma_chan_tb_top.sv
module adma_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        smp_tick, smp_valid, irq;
  logic [15:0] smp_data;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mem [0:511];
  int lat  = 0;
  int mcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .smp_tick(smp_tick), .smp_valid(smp_valid), .smp_data(smp_data), .irq(irq)
  );

  function automatic logic [15:0] halfval(int a);
    return 16'hC000 | 16'((a >> 1) & 16'h3fff);
  endfunction

  // memory: acknowledge with data after lat idle cycles
  initial begin
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0; mcnt = 0;
      end else if (mem_req) begin
        if (mcnt >= lat) begin
          mem_ack = 1'b1; mem_rdata = mem[mem_addr[10:2]];
        end else mcnt++;
      end else mcnt = 0;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 unexpected sample: actual=%h expected=none", smp_data);
      end else begin
        check(tag_q.pop_front(), "sample", 32'(smp_data), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic push(logic [15:0] v, string req);
    exp_q.push_back(v); tag_q.push_back(req);
  endtask

  task automatic reg_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] e, string req, string what);
    @(negedge clk); reg_addr = a; #1;
    check(req, what, reg_rdata, e);
  endtask

  task automatic do_tick();
    @(negedge clk); smp_tick = 1'b1;
    @(negedge clk); smp_tick = 1'b0;
    repeat (TICK_GAP-2) @(negedge clk);
  endtask

  task automatic play(int base, int n, string req);
    for (int k = 0; k < n; k++) push(halfval(base + 2*k), req);
    for (int k = 0; k < n; k++) do_tick();
  endtask

  task automatic set_desc(int idx, int base, int len, logic [31:0] flags);
    mem[2*idx]   = 32'(base);
    mem[2*idx+1] = flags | 32'(len);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; smp_tick = 1'b0;
    for (int w = 0; w < 512; w++) mem[w] = {halfval(4*w+2), halfval(4*w)};
    wait_cyc(3); rst_n = 1'b1; wait_cyc(1);

    // R1 reset state
    rd_chk(4'h6, 32'h01, "R1", "status");
    rd_chk(4'h4, 32'h00, "R1", "current index");
    rd_chk(4'hA, 32'h01, "R1", "next index");
    rd_chk(4'h8, 32'h00, "R1", "position");
    check("R1", "irq/mem_req/smp_valid", {29'd0, irq, mem_req, smp_valid}, 32'h0);

    // R2 R3 R4 R5 R7: three buffers, one starting on an upper half, one with completion bit
    set_desc(0, 'h100, 3, 32'h0);
    set_desc(1, 'h182, 2, 32'h8000_0000);
    set_desc(2, 'h200, 4, 32'h0);
    reg_wr(4'h0, 32'h0);
    rd_chk(4'h0, 32'h0, "R13", "list base readback");
    reg_wr(4'h5, 32'd2);
    rd_chk(4'h5, 32'd2, "R13", "last-valid readback");
    reg_wr(4'hB, 32'h15);
    wait_cyc(30);
    push(halfval('h100), "R2");
    do_tick();
    rd_chk(4'h8, 32'd2, "R4", "position after one sample");
    play('h102, 2, "R3");
    play('h182, 2, "R2");
    play('h200, 4, "R3");
    wait_cyc(5);
    rd_chk(4'h6, 32'h0F, "R7", "status after last buffer");
    rd_chk(4'h4, 32'd2, "R5", "index held at last valid");
    rd_chk(4'hA, 32'd3, "R3", "next index");
    rd_chk(4'h8, 32'd0, "R4", "position at end");
    check("R5", "no fetch while halted", {31'd0, mem_req}, 32'h0);
    check("R11", "irq with flags enabled", {31'd0, irq}, 32'h1);

    // R8 write-1-to-clear
    reg_wr(4'h6, 32'h02);
    rd_chk(4'h6, 32'h0D, "R8", "clear bit 1 only");
    check("R11", "irq still set", {31'd0, irq}, 32'h1);
    reg_wr(4'h6, 32'h0C);
    rd_chk(4'h6, 32'h01, "R8", "clear bits 2,3");
    check("R11", "irq cleared", {31'd0, irq}, 32'h0);
    reg_wr(4'h6, 32'h1F);
    rd_chk(4'h6, 32'h01, "R8", "halted not clearable");

    // R6 resume after moving last-valid, R9 zero fill while halted
    set_desc(3, 'h300, 2, 32'h4000_0000);
    reg_wr(4'h5, 32'd3);
    wait_cyc(30);
    rd_chk(4'h4, 32'd3, "R6", "resumed index");
    play('h300, 2, "R6");
    wait_cyc(5);
    push(16'h0000, "R9");
    do_tick();
    rd_chk(4'h6, 32'h07, "R9", "status: no underrun when halted");

    // R12 soft reset
    reg_wr(4'hB, 32'h02);
    rd_chk(4'h4, 32'h0, "R12", "current index");
    rd_chk(4'h5, 32'h0, "R12", "last valid");
    rd_chk(4'h6, 32'h01, "R12", "status");
    rd_chk(4'h8, 32'h0, "R12", "position");
    rd_chk(4'hB, 32'h0, "R12", "control");
    check("R12", "irq", {31'd0, irq}, 32'h0);

    // R10 pause, R9 repeat-last underrun
    set_desc(0, 'h400, 3, 32'h0);
    reg_wr(4'hB, 32'h09);
    wait_cyc(30);
    push(halfval('h400), "R10");
    do_tick();
    reg_wr(4'hB, 32'h08);
    wait_cyc(10);
    push(halfval('h400), "R10");
    do_tick();
    rd_chk(4'h8, 32'd2, "R10", "position kept while paused");
    rd_chk(4'h6, 32'h02, "R10", "no underrun while paused");
    reg_wr(4'hB, 32'h09);
    wait_cyc(10);
    lat = 40;
    push(halfval('h402), "R10");
    do_tick();
    push(halfval('h402), "R9");
    do_tick();
    rd_chk(4'h6, 32'h12, "R9", "underrun flagged");
    check("R11", "irq on underrun", {31'd0, irq}, 32'h1);
    wait_cyc(50);
    push(halfval('h404), "R9");
    do_tick();
    lat = 0;
    wait_cyc(5);
    rd_chk(4'h6, 32'h17, "R5", "halt after last buffer");

    // R3 index wrap 31 -> 0 with zero-length descriptors
    reg_wr(4'hB, 32'h02);
    for (int i = 0; i < 31; i++) set_desc(i, 'h600, 0, 32'h0);
    set_desc(31, 'h500, 1, 32'h0);
    reg_wr(4'h5, 32'd31);
    reg_wr(4'hB, 32'h01);
    wait_cyc(300);
    rd_chk(4'h4, 32'd31, "R3", "index after empty buffers");
    rd_chk(4'hA, 32'd0, "R3", "next index wraps");
    rd_chk(4'h8, 32'd1, "R4", "position loaded");
    play('h500, 1, "R3");
    wait_cyc(5);
    rd_chk(4'h6, 32'h07, "R5", "halted at index 31");
    set_desc(0, 'h580, 1, 32'h0);
    reg_wr(4'h5, 32'd0);
    wait_cyc(30);
    rd_chk(4'h4, 32'd0, "R3", "index wrapped to 0");
    play('h580, 1, "R3");

    wait_cyc(20);
    check("R3", "all expected samples seen", 32'(exp_q.size()), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule